// File: doc/BRIEF.md
# Codirectional 64 kbit/s Receive Decoder with Octet Slip Buffer

This block takes the two active-low rails of a codirectional 64 kbit/s line, already split by a line receiver, together with a recovered clock strobe that runs at twice the bit rate. Every bit period is sampled twice. The samples are turned into data bits, and a polarity violation marks the last bit of each octet. Finished octets go alternately into two holding registers. The block then sends the newest complete octet as an eight-bit burst on a PCM output. The burst is timed by a local 2 MHz tick and by one of two time-slot envelopes.

The line side and the PCM side run at rates that are close but not identical. When the PCM side reads more slowly than octets arrive, surplus octets are dropped. When it reads faster, the last octet is sent again. Either way, whole octets move intact. If violations stop arriving, framing continues from the last one received (flywheel). A supervision input can blank octets whose boundary was not confirmed. After eight missing violations in a row, an alarm output rises. A blank input forces the output high.

Everything runs on one system clock. The recovered-clock and local-clock edges arrive as one-cycle enable strobes. After reset, the first recovered strobe is assumed to fall in the first half of a bit.

Top module: `cdr_codir_rx`

## Requirements
- R1: Both line rails are active low: a mark is positive when `line_pos_n`=0 and negative when `line_neg_n`=0. Each bit spans two `rec_tick` strobes. A mark in the first half gives data 1, and a mark in the second half gives data 0. The polarity of the bit is the polarity of that mark.
- R2: A bit whose polarity equals the polarity of the previous bit is a violation. It ends an octet and resets alignment so that the next bit starts a new octet. The first bit received in an octet is the first bit sent on `pcm_out`.
- R3: Completed octets are written alternately into two registers. At the first tick of a time-slot, the reader takes the register written most recently.
- R4: On each `loc_tick` strobe while the selected envelope is high, `pcm_out` presents the next bit of the octet, most significant first. On a strobe with the envelope low, `pcm_out` goes high. Before any octet has been stored, bursts are all ones.
- R5: `slot_pick`=1 selects the envelope `slot_a`, and `slot_pick`=0 selects `slot_b`.
- R6: If more than one octet completes between bursts, only the newest one is sent and the others are dropped. If no octet completes between bursts, the previous octet is sent again. Bit order inside an octet is kept in both cases.
- R7: When no violation arrives, an octet boundary is assumed every eight bits after the last violation. Before the first violation, no octet is stored.
- R8: When `superv_n`=0, a burst whose octet ended without a violation is sent as all ones.
- R9: `oct_alarm` rises when the eighth successive octet ends without a violation. It clears when the next violation is received.
- R10: `blank`=1 forces `pcm_out` high on the following clock.
- R11: After reset, `pcm_out`=1 and `oct_alarm`=0.
- R12: An incoming octet never overwrites the register that is in the middle of a burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rec_tick | input | 1 | Recovered half-bit strobe, two per bit |
| line_pos_n | input | 1 | Positive mark rail, active low |
| line_neg_n | input | 1 | Negative mark rail, active low |
| loc_tick | input | 1 | Local 2 MHz rising-edge strobe |
| slot_a | input | 1 | Time-slot envelope, choice 1 |
| slot_b | input | 1 | Time-slot envelope, choice 2 |
| slot_pick | input | 1 | Envelope select, 1 selects slot_a |
| superv_n | input | 1 | Supervision, low blanks unconfirmed octets |
| blank | input | 1 | Forces PCM output high |
| pcm_out | output | 1 | Serial PCM burst output |
| oct_alarm | output | 1 | Loss of octet-timing violations |

## Verification
Some properties are checked on every cycle. These are the local ones: a decoded bit appears only after a recovered strobe, the alarm rises only with an octet that had no violation, and a violation clears it. They also cover the output going high after `blank` or after a tick outside the envelope, and the burst register staying unchanged while it is being read. Other behaviour needs the bench's reference model running over whole scenarios: the decoded values, octet alignment, dropped and repeated octets when the two rates differ, flywheel framing, and supervision blanking. The model checks `pcm_out` and `oct_alarm` on every clock.

// File: rtl/cdr_codir_rx_pkg.sv
// Shared types for the codirectional receive path.
package cdr_codir_rx_pkg;
    // One decoded line bit with its octet-end marker.
    typedef struct packed {
        logic val;
        logic viol;
    } dec_bit_t;
endpackage

// File: rtl/cdr_halfbit_decoder.sv
// Half-bit decoder. Samples the active-low rails on every recovered strobe,
// pairs two samples into one bit and flags polarity violations.
// Assumes: the first strobe after reset falls in the first half of a bit.
module cdr_halfbit_decoder
    import cdr_codir_rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     rec_tick,
    input  logic     pos_n,
    input  logic     neg_n,
    output logic     bit_vld,
    output dec_bit_t bit_out
);
    logic ph;
    logic s0_mark;
    logic s0_pos;
    logic last_pos;
    logic have_last;
    logic mark_now;
    logic pos_now;
    logic cur_pos;

    // Current sample and the polarity of the bit being completed.
    always_comb begin
        mark_now = !pos_n || !neg_n;
        pos_now  = !pos_n;
        if (s0_mark)       cur_pos = s0_pos;
        else if (mark_now) cur_pos = pos_now;
        else               cur_pos = !last_pos;
    end

    // Half-bit phase, first-half capture and bit emission.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph        <= 1'b0;
            s0_mark   <= 1'b0;
            s0_pos    <= 1'b0;
            last_pos  <= 1'b0;
            have_last <= 1'b0;
            bit_vld   <= 1'b0;
            bit_out   <= '0;
        end else begin
            bit_vld <= 1'b0;
            if (rec_tick) begin
                ph <= !ph;
                if (!ph) begin
                    s0_mark <= mark_now;
                    s0_pos  <= pos_now;
                end else begin
                    bit_vld      <= 1'b1;
                    bit_out.val  <= s0_mark;
                    bit_out.viol <= have_last && (cur_pos == last_pos);
                    last_pos     <= cur_pos;
                    have_last    <= 1'b1;
                end
            end
        end
    end

    // R1: a decoded bit only follows a recovered strobe.
    a_r1_bit_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        bit_vld |-> $past(rec_tick));
endmodule

// File: rtl/cdr_octet_framer.sv
// Octet framer. Shifts decoded bits in, ends an octet on a violation or,
// by flywheel, eight bits after the last boundary, and supervises violations.
// Assumes: bits arrive at most once per clock as one-cycle strobes.
module cdr_octet_framer
    import cdr_codir_rx_pkg::*;
#(
    parameter int OCT_W      = 8,
    parameter int MISS_LIMIT = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_vld,
    input  dec_bit_t         bit_in,
    output logic             oct_vld,
    output logic [OCT_W-1:0] oct_data,
    output logic             oct_miss,
    output logic             alarm
);
    localparam int CW = $clog2(OCT_W);
    localparam int MW = $clog2(MISS_LIMIT + 1);

    logic [OCT_W-1:0] sreg;
    logic [OCT_W-1:0] word_next;
    logic [CW-1:0]    cnt;
    logic             synced;
    logic [MW-1:0]    miss_cnt;
    logic             last_slot;

    // Word including the incoming bit, and end-of-octet position.
    always_comb begin
        word_next = {sreg[OCT_W-2:0], bit_in.val};
        last_slot = (cnt == CW'(OCT_W - 1));
    end

    // Bit counting, octet emission and missing-violation supervision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg     <= '0;
            cnt      <= '0;
            synced   <= 1'b0;
            miss_cnt <= '0;
            alarm    <= 1'b0;
            oct_vld  <= 1'b0;
            oct_data <= '0;
            oct_miss <= 1'b0;
        end else begin
            oct_vld <= 1'b0;
            if (bit_vld) begin
                sreg <= word_next;
                if (bit_in.viol) begin
                    cnt      <= '0;
                    synced   <= 1'b1;
                    oct_vld  <= 1'b1;
                    oct_data <= word_next;
                    oct_miss <= 1'b0;
                    miss_cnt <= '0;
                    alarm    <= 1'b0;
                end else if (last_slot) begin
                    cnt <= '0;
                    if (synced) begin
                        oct_vld  <= 1'b1;
                        oct_data <= word_next;
                        oct_miss <= 1'b1;
                        if (miss_cnt != MW'(MISS_LIMIT)) miss_cnt <= miss_cnt + 1'b1;
                        if (miss_cnt >= MW'(MISS_LIMIT - 1)) alarm <= 1'b1;
                    end
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // R2: an octet is only produced from a decoded bit.
    a_r2_octet_from_bit: assert property (@(posedge clk) disable iff (!rst_n)
        oct_vld |-> $past(bit_vld));
    // R9: the alarm rises only together with an octet lacking its violation.
    a_r9_alarm_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm) |-> (oct_vld && oct_miss));
    // R9: a received violation clears the alarm and closes a confirmed octet.
    a_r9_alarm_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bit_vld && bit_in.viol) |-> (!alarm && oct_vld && !oct_miss));
endmodule

// File: rtl/cdr_pingpong.sv
// Two-entry octet store. Each new octet goes to the register not written
// last, unless that register is mid-burst; then the newest one is replaced.
// Assumes: at most one write per clock.
module cdr_pingpong #(
    parameter int OCT_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [OCT_W-1:0]      wr_data,
    input  logic                  wr_miss,
    input  logic                  burst,
    input  logic                  rd_sel,
    output logic [1:0][OCT_W-1:0] words,
    output logic [1:0]            valid,
    output logic [1:0]            missf,
    output logic                  newest
);
    logic target;

    // Pick the register to fill, steering clear of an active burst.
    always_comb begin
        target = burst ? !rd_sel : !newest;
    end

    // Track which register holds the most recent octet.
    always_ff @(posedge clk) begin
        if (!rst_n)     newest <= 1'b0;
        else if (wr_en) newest <= target;
    end

    for (genvar g = 0; g < 2; g++) begin : g_entry
        // Load this entry when it is the chosen target.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                words[g] <= '0;
                valid[g] <= 1'b0;
                missf[g] <= 1'b0;
            end else if (wr_en && (target == 1'(g))) begin
                words[g] <= wr_data;
                valid[g] <= 1'b1;
                missf[g] <= wr_miss;
            end
        end
    end

    // R3: after a write the newest register holds the written octet.
    a_r3_newest_written: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (valid[newest] && words[newest] == $past(wr_data)));
endmodule

// File: rtl/cdr_slot_serializer.sv
// Time-slot serializer. On each local tick inside the selected envelope it
// sends the next bit of the chosen octet, and holds the line high elsewhere.
// Assumes: the envelope spans OCT_W local ticks and is stable between ticks.
module cdr_slot_serializer #(
    parameter int OCT_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  loc_tick,
    input  logic                  slot_a,
    input  logic                  slot_b,
    input  logic                  slot_pick,
    input  logic                  blank,
    input  logic                  superv_n,
    input  logic [1:0][OCT_W-1:0] words,
    input  logic [1:0]            valid,
    input  logic [1:0]            missf,
    input  logic                  newest,
    output logic                  burst,
    output logic                  rd_sel,
    output logic                  pcm_out
);
    localparam int IW = $clog2(OCT_W);

    logic [IW-1:0]    idx;
    logic             ts_sel;
    logic             first;
    logic             use_sel;
    logic [OCT_W-1:0] cur_word;
    logic [OCT_W-1:0] held_word;
    logic             cur_bit;
    logic             suppress;

    // Envelope choice, register choice and the bit due at this tick.
    always_comb begin
        ts_sel    = slot_pick ? slot_a : slot_b;
        first     = (idx == '0);
        use_sel   = first ? newest : rd_sel;
        cur_word  = words[use_sel];
        held_word = words[rd_sel];
        cur_bit   = cur_word[IW'(OCT_W - 1) - idx];
        suppress  = !valid[use_sel] || (!superv_n && missf[use_sel]);
        burst     = !first;
    end

    // Bit position in the burst and the register latched at its start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx    <= '0;
            rd_sel <= 1'b0;
        end else if (loc_tick) begin
            if (ts_sel) begin
                idx <= (idx == IW'(OCT_W - 1)) ? '0 : idx + 1'b1;
                if (first) rd_sel <= newest;
            end else begin
                idx <= '0;
            end
        end
    end

    // Output register with blanking priority.
    always_ff @(posedge clk) begin
        if (!rst_n)        pcm_out <= 1'b1;
        else if (blank)    pcm_out <= 1'b1;
        else if (loc_tick) pcm_out <= (!ts_sel || suppress) ? 1'b1 : cur_bit;
    end

    // R10: blanking forces the output high on the next clock.
    a_r10_blank_high: assert property (@(posedge clk) disable iff (!rst_n)
        $past(blank) |-> pcm_out);
    // R4: a tick outside the envelope leaves the output high.
    a_r4_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        $past(loc_tick && !ts_sel) |-> pcm_out);
    // R12: the register being read stays unchanged through its burst.
    a_r12_burst_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (burst && $past(burst) && $stable(rd_sel)) |-> $stable(held_word));
endmodule

// File: rtl/cdr_codir_rx.sv
// Codirectional receive decoder top: half-bit decoder, octet framer,
// two-entry octet store and time-slot serializer in one clock domain.
// Assumes: rec_tick and loc_tick are one-cycle enables derived elsewhere.
module cdr_codir_rx
    import cdr_codir_rx_pkg::*;
#(
    parameter int OCT_W      = 8,
    parameter int MISS_LIMIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rec_tick,
    input  logic line_pos_n,
    input  logic line_neg_n,
    input  logic loc_tick,
    input  logic slot_a,
    input  logic slot_b,
    input  logic slot_pick,
    input  logic superv_n,
    input  logic blank,
    output logic pcm_out,
    output logic oct_alarm
);
    logic                  bit_vld;
    dec_bit_t              dbit;
    logic                  oct_vld;
    logic [OCT_W-1:0]      oct_data;
    logic                  oct_miss;
    logic [1:0][OCT_W-1:0] words;
    logic [1:0]            valid;
    logic [1:0]            missf;
    logic                  newest;
    logic                  burst;
    logic                  rd_sel;

    cdr_halfbit_decoder u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .rec_tick (rec_tick),
        .pos_n    (line_pos_n),
        .neg_n    (line_neg_n),
        .bit_vld  (bit_vld),
        .bit_out  (dbit)
    );

    cdr_octet_framer #(.OCT_W(OCT_W), .MISS_LIMIT(MISS_LIMIT)) u_frm (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_vld  (bit_vld),
        .bit_in   (dbit),
        .oct_vld  (oct_vld),
        .oct_data (oct_data),
        .oct_miss (oct_miss),
        .alarm    (oct_alarm)
    );

    cdr_pingpong #(.OCT_W(OCT_W)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (oct_vld),
        .wr_data (oct_data),
        .wr_miss (oct_miss),
        .burst   (burst),
        .rd_sel  (rd_sel),
        .words   (words),
        .valid   (valid),
        .missf   (missf),
        .newest  (newest)
    );

    cdr_slot_serializer #(.OCT_W(OCT_W)) u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .loc_tick  (loc_tick),
        .slot_a    (slot_a),
        .slot_b    (slot_b),
        .slot_pick (slot_pick),
        .blank     (blank),
        .superv_n  (superv_n),
        .words     (words),
        .valid     (valid),
        .missf     (missf),
        .newest    (newest),
        .burst     (burst),
        .rd_sel    (rd_sel),
        .pcm_out   (pcm_out)
    );
endmodule

// File: tb/tb_cdr_codir_rx.sv
// Bench: generates a codirectional line and local time-slots, runs a
// behavioural reference model and compares both outputs on every clock.
module tb_cdr_codir_rx;
    localparam int RT = 8;
    localparam int A0 = 3;
    localparam int B0 = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rec_tick = 1'b0, line_pos_n = 1'b1, line_neg_n = 1'b1;
    logic loc_tick = 1'b0, slot_a = 1'b0, slot_b = 1'b0;
    logic slot_pick = 1'b1, superv_n = 1'b1, blank = 1'b0;
    logic pcm_out, oct_alarm;

    cdr_codir_rx dut (
        .clk(clk), .rst_n(rst_n), .rec_tick(rec_tick),
        .line_pos_n(line_pos_n), .line_neg_n(line_neg_n),
        .loc_tick(loc_tick), .slot_a(slot_a), .slot_b(slot_b),
        .slot_pick(slot_pick), .superv_n(superv_n), .blank(blank),
        .pcm_out(pcm_out), .oct_alarm(oct_alarm)
    );

    always #5 clk = ~clk;

    // scenario configuration, written by the main sequence at posedge
    int    cfg_fr = 64;
    bit    cfg_viol = 1'b1, cfg_pick = 1'b1, cfg_sup = 1'b1, cfg_blk = 1'b0;
    string cur_req = "R11";
    int    total = 0, bad = 0, cyc = 0;
    bit    finished = 1'b0;

    // generator state
    int rc = 0, hh = 0, bidx = 0, octn = 0, lc = 0, sk = 0;
    bit gpol = 1'b0, cur_b = 1'b0, cur_p = 1'b0;
    int gw = 0;

    // reference model state
    int m_ph, m_s0mark, m_s0pos, m_lastpos, m_have, m_sreg, m_cnt, m_sync, m_miss;
    int mb[2], mv[2], mm[2], m_new, m_idx, m_rsel;
    int pw, pw_d, pw_m, pa, pa_v;
    bit e_pcm = 1'b1, e_alarm = 1'b0;

    task automatic check(input string req, input bit act, input bit exp, input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0b expected=%0b at cycle %0d", req, what, act, exp, cyc);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    task automatic model_reset();
        m_ph = 0; m_s0mark = 0; m_s0pos = 0; m_lastpos = 0; m_have = 0;
        m_sreg = 0; m_cnt = 0; m_sync = 0; m_miss = 0;
        for (int i = 0; i < 2; i++) begin mb[i] = 0; mv[i] = 0; mm[i] = 0; end
        m_new = 0; m_idx = 0; m_rsel = 0; pw = 0; pa = 0;
        e_pcm = 1'b1; e_alarm = 1'b0;
    endtask

    // one clock edge of the reference behaviour, with the inputs just driven
    task automatic model_step();
        int burst0, rsel0, sel, tgt, pos, mark, b, vio, word;
        bit ts, newpcm;
        newpcm = e_pcm;
        if (pa > 0) begin pa--; if (pa == 0) e_alarm = bit'(pa_v); end
        burst0 = (m_idx != 0) ? 1 : 0;
        rsel0  = m_rsel;
        ts = slot_pick ? slot_a : slot_b;
        if (loc_tick) begin
            if (ts) begin
                sel = (m_idx == 0) ? m_new : m_rsel;
                if (m_idx == 0) m_rsel = m_new;
                if (mv[sel] == 0 || (!superv_n && mm[sel] != 0)) newpcm = 1'b1;
                else newpcm = bit'((mb[sel] >> (7 - m_idx)) & 1);
                m_idx = (m_idx + 1) % 8;
            end else begin
                m_idx = 0;
                newpcm = 1'b1;
            end
        end
        if (blank) e_pcm = 1'b1;
        else if (loc_tick) e_pcm = newpcm;
        if (pw > 0) begin
            pw--;
            if (pw == 0) begin
                tgt = (burst0 != 0) ? 1 - rsel0 : 1 - m_new;
                mb[tgt] = pw_d; mv[tgt] = 1; mm[tgt] = pw_m; m_new = tgt;
            end
        end
        if (rec_tick) begin
            mark = (!line_pos_n || !line_neg_n) ? 1 : 0;
            pos  = (!line_pos_n) ? 1 : 0;
            if (m_ph == 0) begin
                m_s0mark = mark; m_s0pos = pos;
            end else begin
                b = m_s0mark;
                if (m_s0mark != 0) pos = m_s0pos;
                vio = (m_have != 0 && pos == m_lastpos) ? 1 : 0;
                m_lastpos = pos; m_have = 1;
                m_sreg = ((m_sreg << 1) | b) & 255;
                word = m_sreg;
                if (vio != 0) begin
                    m_cnt = 0; m_sync = 1; m_miss = 0;
                    pw = 2; pw_d = word; pw_m = 0;
                    pa = 1; pa_v = 0;
                end else if (m_cnt == 7) begin
                    m_cnt = 0;
                    if (m_sync != 0) begin
                        pw = 2; pw_d = word; pw_m = 1;
                        if (m_miss < 8) m_miss++;
                        if (m_miss >= 8) begin pa = 1; pa_v = 1; end
                    end
                end else begin
                    m_cnt++;
                end
            end
            m_ph = 1 - m_ph;
        end
    endtask

    // compare, drive the next inputs, then advance the model
    always @(negedge clk) begin
        bit mk;
        cyc++;
        if (cyc > 2 && !finished) begin
            check(cur_req, pcm_out, e_pcm, "pcm_out");
            check("R9", oct_alarm, e_alarm, "oct_alarm");
        end
        if (cyc > 150000) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            report();
        end
        rst_n = (cyc >= 5);
        blank = cfg_blk; superv_n = cfg_sup; slot_pick = cfg_pick;
        if (!rst_n) begin
            rc = 0; hh = 0; bidx = 0; octn = 0; lc = 0; sk = 0; gpol = 1'b0;
            rec_tick = 1'b0; loc_tick = 1'b0; slot_a = 1'b0; slot_b = 1'b0;
            line_pos_n = 1'b1; line_neg_n = 1'b1;
            model_reset();
        end else begin
            if (rc == 0) begin
                if (hh == 0) begin
                    if (bidx == 0) begin gw = (8'h3C ^ (octn * 37)) & 255; octn++; end
                    cur_b = bit'((gw >> (7 - bidx)) & 1);
                    cur_p = (bidx == 7 && cfg_viol) ? gpol : !gpol;
                    gpol = cur_p;
                    bidx = (bidx + 1) % 8;
                    mk = cur_b;
                end else begin
                    mk = !cur_b;
                end
                line_pos_n = !(mk && cur_p);
                line_neg_n = !(mk && !cur_p);
                hh = 1 - hh;
            end
            rec_tick = (rc == RT / 2);
            rc = (rc + 1) % RT;
            loc_tick = (lc == 0);
            if (loc_tick) begin
                slot_a = (sk >= A0 && sk < A0 + 8);
                slot_b = (sk >= B0 && sk < B0 + 8);
                sk = (sk + 1) % cfg_fr;
            end
            lc = (lc + 1) % 2;
            model_step();
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        // R11: reset state
        #1 check("R11", pcm_out, 1'b1, "pcm_out after reset");
        check("R11", oct_alarm, 1'b0, "oct_alarm after reset");
        // R1/R2/R3/R4: nominal decode and bursts on the first envelope
        cur_req = "R1/R2/R3/R4";
        repeat (6000) @(posedge clk);
        // R5: second envelope
        cfg_pick = 1'b0; cur_req = "R5";
        repeat (3000) @(posedge clk);
        // R6: slow reader drops octets, R12 exercised by drifting slots
        cfg_pick = 1'b1; cfg_fr = 72; cur_req = "R6/R12 slow";
        repeat (5000) @(posedge clk);
        // R6: fast reader repeats octets
        cfg_fr = 56; cur_req = "R6/R12 fast";
        repeat (5000) @(posedge clk);
        // R7 and R9: violations stop, flywheel framing, alarm after eight
        cfg_fr = 64; cfg_viol = 1'b0; cur_req = "R7";
        repeat (2200) @(posedge clk);
        #1 check("R9", oct_alarm, 1'b1, "alarm after missing violations");
        // R8: supervision blanks unconfirmed octets
        cfg_sup = 1'b0; cur_req = "R8";
        repeat (2000) @(posedge clk);
        // R9: violations return and clear the alarm
        cfg_viol = 1'b1; cur_req = "R9";
        repeat (1500) @(posedge clk);
        #1 check("R9", oct_alarm, 1'b0, "alarm after violation returns");
        // R10: blanking
        cfg_sup = 1'b1; cfg_blk = 1'b1; cur_req = "R10";
        repeat (400) @(posedge clk);
        #1 check("R10", pcm_out, 1'b1, "pcm_out while blanked");
        cfg_blk = 1'b0; cur_req = "R4";
        repeat (600) @(posedge clk);
        report();
    end
endmodule